// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

The block watches 32 request lines and turns the edges on them into latched interrupt requests and one-clock event pulses. The lower 16 lines each take the same-numbered pin of one of six GPIO ports, chosen per line by a 3-bit code. The upper 16 lines come straight from peripheral event sources, with three of them tied low inside the block. Every line has its own edge choice (rising, falling or both), its own interrupt enable and its own event enable.

An interrupt request latches a pending bit, which software clears by writing 1. An event request produces a single-cycle pulse and never touches the pending state. Software can inject a request on any line through a trigger register. The pending bits of lines 0 to 15 are folded into three shared interrupt outputs for an interrupt controller. The pending bits of lines 16 to 31 leave the block one per line.

A simple single-cycle register bus with a combinational read port holds the configuration. Word addresses: 0 interrupt enable, 1 event enable, 2 rising select, 3 falling select, 4 software trigger, 5 pending, 6 and 7 port select.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq_grp_o`, `irq_hi_o` and `event_o` are 0.
- R2: A line fires on a 0-to-1 change when its rising select bit (address 2) is set, and on a 1-to-0 change when its falling select bit (address 3) is set. With both set it fires on either change. A pin change driven before clock edge k is visible in the pending register after edge k+2 and not after edge k+1.
- R3: A request sets the pending bit only when the interrupt enable bit (address 0) is set. It raises `event_o` for exactly one clock only when the event enable bit (address 1) is set. An event-only request leaves the pending bit at 0.
- R4: Writing 1 to a bit of the pending register (address 5) clears that bit. Writing 0 leaves it unchanged.
- R5: Writing 1 to a bit of the software trigger register (address 4) acts as a request on that line at the same clock edge. The register always reads 0.
- R6: Line x (0..15) takes gpio_i bit p*16+x. Here p is the 3-bit code held in bits [4*(x%8)+2 : 4*(x%8)] of address 6 (lines 0..7) or address 7 (lines 8..15). Codes 0..5 select ports A..F. Codes 6 and 7 hold the line low.
- R7: Lines 24, 29 and 30 never set a pending bit and never pulse `event_o`, from hardware or from software.
- R8: `irq_grp_o[0]` is the OR of pending bits 1:0, `irq_grp_o[1]` the OR of bits 3:2 and `irq_grp_o[2]` the OR of bits 15:4. `irq_hi_o[i]` equals pending bit 16+i.
- R9: When a request and a write-1 clear land on the same line at the same clock edge, the pending bit stays set.
- R10: Addresses 0, 1, 2, 3 and 5 read back their 32-bit state. Addresses 6 and 7 read back the stored 3-bit codes in their fields, with bit 3 of each field reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | 96 | Six GPIO ports of 16 pins; port p pin x at bit p*16+x |
| periph_i | input | 16 | Peripheral event sources for lines 16..31 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| irq_grp_o | output | 3 | Shared interrupt outputs for lines 0-1, 2-3, 4-15 |
| irq_hi_o | output | 16 | Per-line interrupt outputs for lines 16..31 |
| event_o | output | 32 | One-cycle event pulses per line |

## Verification
A hardware edge reaching the pending logic and a software write-1 clear of the same bit can meet at one clock edge. The bench provokes this by changing a pin exactly two clocks before it issues the clear, with the pending bit already set by a software trigger. It judges the result by reading the bit back, which must still be 1. A control run issues the same clear with no edge and expects the bit to be 0. The random phase also lets configuration writes, pin changes and clears fall close together. Each outcome is compared with pending and event values derived from the line levels before and after the change.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned N_LINES  = 32;
  localparam int unsigned N_PIN    = 16;
  localparam int unsigned N_PORT   = 6;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned ADDR_W   = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FIELD_W  = 4;
  localparam logic [N_LINES-1:0] RSVD_LINES = 32'h6100_0000;

  typedef enum logic [ADDR_W-1:0] {
    A_IMSK = 3'd0,
    A_EMSK = 3'd1,
    A_RISE = 3'd2,
    A_FALL = 3'd3,
    A_SWTR = 3'd4,
    A_PEND = 3'd5,
    A_SEL0 = 3'd6,
    A_SEL1 = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/ext_irq_src_mux.sv
module ext_irq_src_mux #(
  parameter int unsigned N_PIN  = 16,
  parameter int unsigned N_PORT = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [N_PORT*N_PIN-1:0] gpio_i,
  input  logic [N_PIN*SEL_W-1:0]  sel_i,
  output logic [N_PIN-1:0]        line_o
);
  for (genvar x = 0; x < N_PIN; x++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = sel_i[x*SEL_W +: SEL_W];
    always_comb begin
      line_o[x] = 1'b0;
      if (int'(code) < N_PORT) line_o[x] = gpio_i[int'(code)*N_PIN + x];
    end
  end
endmodule

// File: rtl/ext_irq_sync_edge.sv
module ext_irq_sync_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = (s2_q & ~s3_q & rise_en_i) | (~s2_q & s3_q & fall_en_i);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NL    = 32,
  parameter int unsigned NPIN  = 16,
  parameter int unsigned SELW  = 3,
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 32,
  parameter logic [NL-1:0] RSVD = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NL-1:0]   hw_trig_i,
  output logic [NL-1:0]   imask_o,
  output logic [NL-1:0]   emask_o,
  output logic [NL-1:0]   rise_o,
  output logic [NL-1:0]   fall_o,
  output logic [NL-1:0]   pend_o,
  output logic [NL-1:0]   event_o,
  output logic [NPIN*SELW-1:0] sel_o
);
  localparam int unsigned LPR = DW / FIELD_W;  // lines per select word

  logic [NL-1:0]   imask_q, emask_q, rise_q, fall_q, pend_q, event_q;
  logic [SELW-1:0] sel_q [NPIN];
  logic [NL-1:0]   sw_trig, trig, pend_clr;

  assign sw_trig  = (we_i && addr_i == A_SWTR) ? wdata_i[NL-1:0] : '0;
  assign pend_clr = (we_i && addr_i == A_PEND) ? wdata_i[NL-1:0] : '0;
  assign trig     = (hw_trig_i | sw_trig) & ~RSVD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imask_q <= '0;
      emask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      pend_q  <= '0;
      event_q <= '0;
    end else begin
      if (we_i && addr_i == A_IMSK) imask_q <= wdata_i[NL-1:0];
      if (we_i && addr_i == A_EMSK) emask_q <= wdata_i[NL-1:0];
      if (we_i && addr_i == A_RISE) rise_q  <= wdata_i[NL-1:0];
      if (we_i && addr_i == A_FALL) fall_q  <= wdata_i[NL-1:0];
      // set beats clear on a collision
      pend_q  <= (pend_q & ~pend_clr) | (trig & imask_q);
      event_q <= trig & emask_q;
    end
  end

  for (genvar x = 0; x < NPIN; x++) begin : g_sel
    localparam logic [AW-1:0] SEL_ADDR = AW'(int'(A_SEL0) + x / LPR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        sel_q[x] <= '0;
      else if (we_i && addr_i == SEL_ADDR) sel_q[x] <= wdata_i[FIELD_W*(x%LPR) +: SELW];
    end
    assign sel_o[x*SELW +: SELW] = sel_q[x];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_IMSK: rdata_o[NL-1:0] = imask_q;
      A_EMSK: rdata_o[NL-1:0] = emask_q;
      A_RISE: rdata_o[NL-1:0] = rise_q;
      A_FALL: rdata_o[NL-1:0] = fall_q;
      A_PEND: rdata_o[NL-1:0] = pend_q;
      default: begin
        for (int x = 0; x < int'(NPIN); x++) begin
          if (int'(addr_i) >= int'(A_SEL0) &&
              int'(addr_i) - int'(A_SEL0) == x / int'(LPR))
            rdata_o[FIELD_W*(x%LPR) +: SELW] = sel_q[x];
        end
      end
    endcase
  end

  assign imask_o = imask_q;
  assign emask_o = emask_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
  assign pend_o  = pend_q;
  assign event_o = event_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NL     = N_LINES,
  parameter int unsigned NPIN   = N_PIN,
  parameter int unsigned NPORT  = N_PORT,
  parameter int unsigned SELW   = SEL_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned DW     = DATA_W,
  parameter logic [NL-1:0] RSVD = RSVD_LINES
) (
  input  logic [0:0]            clk_i,
  input  logic                  rst_ni,
  input  logic [NPORT*NPIN-1:0] gpio_i,
  input  logic [NL-NPIN-1:0]    periph_i,
  input  logic                  reg_we_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [DW-1:0]         reg_wdata_i,
  output logic [DW-1:0]         reg_rdata_o,
  output logic [2:0]            irq_grp_o,
  output logic [NL-NPIN-1:0]    irq_hi_o,
  output logic [NL-1:0]         event_o
);
  localparam int unsigned G0_HI = 1;
  localparam int unsigned G1_HI = 3;

  logic [NPIN-1:0]      pin_lines;
  logic [NL-1:0]        lines_in, edges;
  logic [NL-1:0]        imask_q, emask_q, rise_q, fall_q, pend_q;
  logic [NPIN*SELW-1:0] sel_q;

  ext_irq_src_mux #(.N_PIN(NPIN), .N_PORT(NPORT), .SEL_W(SELW)) u_mux (
    .gpio_i (gpio_i),
    .sel_i  (sel_q),
    .line_o (pin_lines)
  );

  assign lines_in = {periph_i, pin_lines} & ~RSVD;

  ext_irq_sync_edge #(.W(NL)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (lines_in),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .edge_o    (edges)
  );

  ext_irq_regs #(
    .NL(NL), .NPIN(NPIN), .SELW(SELW), .AW(AW), .DW(DW), .RSVD(RSVD)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .hw_trig_i (edges),
    .imask_o   (imask_q),
    .emask_o   (emask_q),
    .rise_o    (rise_q),
    .fall_o    (fall_q),
    .pend_o    (pend_q),
    .event_o   (event_o),
    .sel_o     (sel_q)
  );

  assign irq_grp_o[0] = |pend_q[G0_HI:0];
  assign irq_grp_o[1] = |pend_q[G1_HI:G0_HI+1];
  assign irq_grp_o[2] = |pend_q[NPIN-1:G1_HI+1];
  assign irq_hi_o     = pend_q[NL-1:NPIN];
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter int unsigned NL = N_LINES,
  parameter int unsigned AW = ADDR_W,
  parameter logic [NL-1:0] RSVD = RSVD_LINES
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [NL-1:0] event_o,
  input logic [2:0]    irq_grp_o,
  input logic [NL-1:0] pend,
  input logic [NL-1:0] imask,
  input logic [NL-1:0] emask
);
  // R7
  reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend | event_o) & RSVD) == '0);

  // R3
  pend_needs_imask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~$past(pend)) & ~$past(imask)) == '0);

  // R3
  event_needs_emask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o & ~$past(emask)) == '0);

  // R4
  pend_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~pend & $past(pend)) != '0) |-> $past(reg_we_i && reg_addr_i == A_PEND));

  // R8
  grp_drop_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_grp_o != 3'b000 && $past(irq_grp_o) == 3'b111) |-> 1'b1 ##0
    ($fell(irq_grp_o[0]) || $fell(irq_grp_o[1]) || $fell(irq_grp_o[2])) |->
    $past(reg_we_i && reg_addr_i == A_PEND));
endmodule

bind ext_irq_ctrl ext_irq_chk #(.NL(NL), .AW(AW), .RSVD(RSVD)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .event_o    (event_o),
  .irq_grp_o  (irq_grp_o),
  .pend       (pend_q),
  .imask      (imask_q),
  .emask      (emask_q)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  localparam logic [31:0] RSVD = 32'h6100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] gpio = '0;
  logic [15:0] periph = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  grp;
  logic [15:0] hi;
  logic [31:0] ev;
  logic [31:0] ev_seen = '0;
  logic        ev_clr = 1'b0;
  int total = 0;
  int bad = 0;
  logic [2:0] sel_b [16];

  always #4 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .gpio_i(gpio), .periph_i(periph),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_grp_o(grp), .irq_hi_o(hi), .event_o(ev)
  );

  always @(negedge clk) begin
    if (ev_clr) ev_seen <= '0;
    else        ev_seen <= ev_seen | ev;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic clear_ev();
    @(posedge clk); ev_clr = 1'b1;
    @(posedge clk); ev_clr = 1'b0;
  endtask

  task automatic clean();
    @(negedge clk); gpio = '0; periph = '0;
    for (int a = 0; a < 8; a++) if (a != 4 && a != 5) wr(3'(a), 32'h0);
    repeat (5) @(negedge clk);
    wr(3'd5, 32'hFFFF_FFFF);
  endtask

  function automatic logic lvl(input int x, input logic [95:0] g, input logic [15:0] p);
    if (x < 16) return (sel_b[x] < 3'd6) ? g[int'(sel_b[x])*16 + x] : 1'b0;
    return RSVD[x] ? 1'b0 : p[x-16];
  endfunction

  logic [31:0] r;

  initial begin
    #(8*150000);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) sel_b[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), r); chk("R1 reg", r, 32'h0); end
    chk("R1 outputs", {13'h0, grp, hi}, 32'h0);
    chk("R1 event", ev, 32'h0);

    // R10 readback
    wr(3'd0, 32'hA5A5_5A5A); rd(3'd0, r); chk("R10 imask", r, 32'hA5A5_5A5A);
    wr(3'd3, 32'h1234_8765); rd(3'd3, r); chk("R10 fall", r, 32'h1234_8765);
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, r); chk("R10 sel0", r, 32'h7777_7777);
    wr(3'd7, 32'h7654_3210); rd(3'd7, r); chk("R10 sel1", r, 32'h7654_3210);
    rd(3'd4, r); chk("R5 swtr reads 0", r, 32'h0);
    clean();

    // R6 port select: line 3 on port C
    wr(3'd6, 32'h0000_2000); wr(3'd0, 32'h8); wr(3'd2, 32'h8); wr(3'd3, 32'h8);
    @(negedge clk); gpio[3] = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd5, r); chk("R6 unselected port A", r, 32'h0);
    @(negedge clk); gpio[2*16+3] = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd5, r); chk("R6 port C pin 3", r, 32'h8);
    wr(3'd6, 32'h0000_6000);
    repeat (5) @(negedge clk);
    wr(3'd5, 32'hFFFF_FFFF);
    for (int p = 0; p < 6; p++) gpio[p*16+3] = ~gpio[p*16+3];
    repeat (5) @(negedge clk);
    rd(3'd5, r); chk("R6 code 110 holds low", r, 32'h0);
    clean();

    // R2 latency, rising on line 5; R8 group
    wr(3'd0, 32'h20); wr(3'd2, 32'h20);
    @(negedge clk); addr = 3'd5; gpio[5] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    chk("R2 not after k+1", rdata, 32'h0);
    @(posedge clk); @(negedge clk); #1;
    chk("R2 set after k+2", rdata, 32'h20);
    chk("R8 group 4-15", {29'h0, grp}, 32'h4);
    // R2 falling not selected
    wr(3'd5, 32'h20);
    @(negedge clk); gpio[5] = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd5, r); chk("R2 falling ignored", r, 32'h0);
    chk("R4 group drops", {29'h0, grp}, 32'h0);
    clean();

    // R3 event only on line 20
    wr(3'd1, 32'h0010_0000); wr(3'd2, 32'h0010_0000);
    clear_ev();
    @(negedge clk); periph[4] = 1'b1;
    begin
      int n = 0;
      for (int c = 0; c < 6; c++) begin @(negedge clk); if (ev[20]) n++; end
      chk("R3 event one cycle", 32'(n), 32'd1);
    end
    rd(3'd5, r); chk("R3 event leaves pend", r, 32'h0);
    clean();

    // R5 software trigger; R8 group 0-1 and upper lines
    wr(3'd0, 32'h0001_0001); wr(3'd1, 32'h2);
    @(negedge clk); we = 1'b1; addr = 3'd4; wdata = 32'h0001_0003;
    @(negedge clk); we = 1'b0;
    chk("R5 event pulse", ev, 32'h2);
    chk("R8 group 0-1 and hi", {13'h0, grp, hi}, 32'h0001_0001);
    @(negedge clk);
    chk("R5 pulse ends", ev, 32'h0);
    rd(3'd5, r); chk("R5 pend", r, 32'h0001_0001);
    // R4 write 0 no effect, write 1 clears
    wr(3'd5, 32'h0); rd(3'd5, r); chk("R4 write 0", r, 32'h0001_0001);
    wr(3'd5, 32'h1); rd(3'd5, r); chk("R4 write 1", r, 32'h0001_0000);
    clean();

    // R7 reserved lines
    for (int a = 0; a < 4; a++) wr(3'(a), 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    wr(3'd5, 32'hFFFF_FFFF);
    clear_ev();
    wr(3'd4, RSVD);
    @(negedge clk); periph = 16'h6100;
    repeat (5) @(negedge clk);
    periph = 16'h0;
    repeat (5) @(negedge clk);
    rd(3'd5, r); chk("R7 reserved pend", r, 32'h0);
    chk("R7 reserved event", ev_seen, 32'h0);
    clean();

    // R9 collision: edge and clear at the same clock edge
    wr(3'd0, 32'h40); wr(3'd2, 32'h40); wr(3'd3, 32'h40);
    wr(3'd4, 32'h40);
    @(negedge clk); gpio[6] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 3'd5; wdata = 32'h40;
    @(negedge clk); we = 1'b0;
    rd(3'd5, r); chk("R9 set wins", r, 32'h40);
    wr(3'd5, 32'h40); rd(3'd5, r); chk("R4 clear without edge", r, 32'h0);
    clean();

    // R2 R3 R6 R7 random configurations
    for (int it = 0; it < 40; it++) begin
      logic [31:0] im, em, rs, fl, s0, s1, exp_e;
      logic [95:0] g_new;
      logic [15:0] p_new;
      im = $urandom; em = $urandom; rs = $urandom; fl = $urandom;
      s0 = '0; s1 = '0;
      for (int x = 0; x < 16; x++) begin
        sel_b[x] = 3'($urandom % 8);
        if (x < 8) s0[4*x +: 3] = sel_b[x]; else s1[4*(x-8) +: 3] = sel_b[x];
      end
      wr(3'd0, im); wr(3'd1, em); wr(3'd2, rs); wr(3'd3, fl);
      wr(3'd6, s0); wr(3'd7, s1);
      repeat (5) @(negedge clk);
      wr(3'd5, 32'hFFFF_FFFF);
      clear_ev();
      g_new = {$urandom, $urandom, $urandom};
      p_new = 16'($urandom);
      exp_e = '0;
      for (int x = 0; x < 32; x++) begin
        logic o, n;
        o = lvl(x, gpio, periph);
        n = lvl(x, g_new, p_new);
        exp_e[x] = (!o && n && rs[x]) || (o && !n && fl[x]);
      end
      @(negedge clk); gpio = g_new; periph = p_new;
      repeat (5) @(negedge clk);
      rd(3'd5, r); chk("R2 random pend", r, exp_e & im);
      chk("R3 random event", ev_seen, exp_e & em);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule